// File: doc/BRIEF.md
# Rotating-Priority Vectored Interrupt Controller

This block collects up to eight level-sensitive interrupt lines and presents one request to a processor. Each line can be disabled individually. A line that is pending and enabled, and that ranks above every routine already in progress, drives the processor request. When the processor acknowledges, the controller does three things:

- it records the winning line as in service;
- it drops that line's pending bit for one cycle;
- it returns an 8-bit vector made of a programmable base and the line number.

A routine counts as finished only when software writes an end-of-service command. That command names a line, or it names "whichever in-service line ranks highest". The command frees the line for new requests.

Two ranking schemes are available. In fixed ranking, line 0 is strongest. In rotating ranking, a line whose service has just ended drops to the weakest place, and the line after it becomes strongest, so that equal-importance lines cannot starve one another.

A line can be flagged as leading to a downstream controller. When such a line is acknowledged, the block reports the line number on a separate cascade output instead of driving a vector. While that line is in service, its mask bit is ignored, and further requests on it are still forwarded, so the downstream controller can nest its own inputs.

Top module: `vic_rotor`

## Requirements
- R1: After reset every line is disabled (mask all ones). `int_req`, `vec_valid` and `casc_valid` are low, and a line held high during and after reset raises no request.
- R2: Lines are sampled once per clock. A line that goes high before a clock edge makes `int_req` high right after that edge, provided it is enabled and ranks above all in-service lines.
- R3: A line whose mask bit is 1 never raises `int_req` and is never vectored. The mask is written at register address 0, with bit i belonging to line i.
- R4: In fixed mode (bit 0 of the control register at address 1 is 0), the lowest-numbered eligible line wins.
- R5: An edge where `int_ack` and `int_req` are both high marks the winner in service. After that edge, `vec_valid` is high for exactly one cycle and `vec_out` = {base, line index}. The base is held in bits 7:3 of the control register.
- R6: A pending line is forwarded only if it ranks strictly above every in-service line. A line that ranks equal or lower waits.
- R7: Writing value i with bit 7 = 0 to address 3 clears the in-service bit of line i, and the line may then be requested again.
- R8: Writing bit 7 = 1 to address 3 clears the in-service bit of the highest-ranking in-service line.
- R9: In rotating mode (control bit 0 = 1), ending the service of line k makes line k+1 (wrapping from the last line to 0) the strongest and line k the weakest. The pointer starts at line 0.
- R10: Lines flagged at address 2 (bit i for line i) answer an acknowledge with `casc_valid` high for one cycle and `casc_idx` = the line number. `vec_valid` stays low.
- R11: While a flagged line is in service, its mask bit is ignored and a new request on it is forwarded. Once its service ends, the mask applies again.
- R12: `int_ack` while `int_req` is low changes nothing: no vector, no cascade pulse, and no in-service change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | N_IRQ | Level-sensitive interrupt lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mask, 1 control, 2 cascade flags, 3 end-of-service |
| reg_wdata | input | DATA_W | Write data |
| int_req | output | 1 | Request to the processor |
| int_ack | input | 1 | Processor acknowledge, one cycle |
| vec_out | output | VEC_W | Vector of the last acknowledged non-cascade line |
| vec_valid | output | 1 | One-cycle strobe for `vec_out` |
| casc_valid | output | 1 | One-cycle strobe for a cascade line acknowledge |
| casc_idx | output | IDX_W | Line number of the acknowledged cascade line |

## Verification
The bench builds the controller with its defaults: eight lines, 8-bit data and 8-bit vectors. With these values every line index fills the 3-bit vector field, and the rotation pointer can be driven across the wrap from line 7 back to line 0. The stimulus orders the lines so that nesting puts two routines in service at once. The bench then frees them in different ways: with the specific and the non-specific end-of-service command, and by rotating the ranking until a low-numbered line loses to a higher-numbered one.

// File: rtl/vic_rotor_pkg.sv
package vic_rotor_pkg;

  typedef enum logic [1:0] {
    RA_MASK  = 2'd0,
    RA_CTRL  = 2'd1,
    RA_SLAVE = 2'd2,
    RA_EOI   = 2'd3
  } reg_addr_e;

  localparam int CTRL_ROT_BIT    = 0;
  localparam int EOI_NONSPEC_BIT = 7;

endpackage

// File: rtl/vic_prio_pick.sv
// Finds the first set bit of a vector, searching upward from a start index
// and wrapping around.
module vic_prio_pick #(
  parameter int N_IRQ = 8,
  parameter int IDX_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] cand,
  input  logic [IDX_W-1:0] start,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    int pos;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N_IRQ; k++) begin
      pos = (int'(start) + k) % N_IRQ;
      if (!found && cand[pos]) begin
        found = 1'b1;
        idx   = IDX_W'(pos);
      end
    end
  end

endmodule

// File: rtl/vic_rank_gate.sv
// Decides, for each line, whether it ranks above the strongest in-service line.
module vic_rank_gate #(
  parameter int N_IRQ = 8,
  parameter int IDX_W = $clog2(N_IRQ)
) (
  input  logic [IDX_W-1:0] top_ptr,
  input  logic             isr_any,
  input  logic [IDX_W-1:0] isr_idx,
  input  logic [N_IRQ-1:0] slave,
  output logic [N_IRQ-1:0] allowed
);

  function automatic int rank_of(input int line, input int top);
    return (line - top + N_IRQ) % N_IRQ;
  endfunction

  for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_line
    always_comb begin
      allowed[gi] = !isr_any
                 || (rank_of(gi, int'(top_ptr)) < rank_of(int'(isr_idx), int'(top_ptr)))
                 || (slave[gi] && (isr_idx == IDX_W'(gi)));
    end
  end

endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_rotor_pkg::*;
#(
  parameter int N_IRQ  = 8,
  parameter int IDX_W  = $clog2(N_IRQ),
  parameter int DATA_W = 8,
  parameter int BASE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [N_IRQ-1:0]  mask_q,
  output logic [N_IRQ-1:0]  slave_q,
  output logic              rot_q,
  output logic [BASE_W-1:0] base_q,
  output logic              eoi_fire,
  output logic              eoi_nonspec,
  output logic [IDX_W-1:0]  eoi_idx
);

  logic [N_IRQ-1:0]  mask_d, slave_d;
  logic              rot_d;
  logic [BASE_W-1:0] base_d;
  logic              mask_en, ctrl_en, slave_en;
  logic              unused_wdata_bits;

  assign unused_wdata_bits = ^wdata;

  always_comb begin
    mask_en  = 1'b0;
    ctrl_en  = 1'b0;
    slave_en = 1'b0;
    eoi_fire = 1'b0;
    if (we) begin
      case (reg_addr_e'(addr))
        RA_MASK:  mask_en  = 1'b1;
        RA_CTRL:  ctrl_en  = 1'b1;
        RA_SLAVE: slave_en = 1'b1;
        RA_EOI:   eoi_fire = wdata[EOI_NONSPEC_BIT]
                          || (int'(wdata[IDX_W-1:0]) < N_IRQ);
        default:  ;
      endcase
    end
  end

  assign eoi_nonspec = wdata[EOI_NONSPEC_BIT];
  assign eoi_idx     = wdata[IDX_W-1:0];

  always_comb begin
    mask_d  = mask_en  ? wdata[N_IRQ-1:0] : mask_q;
    slave_d = slave_en ? wdata[N_IRQ-1:0] : slave_q;
    rot_d   = ctrl_en  ? wdata[CTRL_ROT_BIT] : rot_q;
    base_d  = ctrl_en  ? wdata[DATA_W-1 -: BASE_W] : base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      slave_q <= '0;
      rot_q   <= 1'b0;
      base_q  <= '0;
    end else begin
      mask_q  <= mask_d;
      slave_q <= slave_d;
      rot_q   <= rot_d;
      base_q  <= base_d;
    end
  end

endmodule

// File: rtl/vic_service.sv
// Holds the pending and in-service state, the rotation pointer and the
// registered acknowledge outputs.
module vic_service #(
  parameter int N_IRQ  = 8,
  parameter int IDX_W  = $clog2(N_IRQ),
  parameter int BASE_W = 5,
  parameter int VEC_W  = BASE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic              ack_fire,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic              eoi_valid,
  input  logic [IDX_W-1:0]  eoi_tgt,
  input  logic              rot,
  input  logic [BASE_W-1:0] base,
  input  logic [N_IRQ-1:0]  slave,
  output logic [N_IRQ-1:0]  irr_q,
  output logic [N_IRQ-1:0]  isr_q,
  output logic [IDX_W-1:0]  top_q,
  output logic [VEC_W-1:0]  vec_q,
  output logic              vec_valid_q,
  output logic              casc_valid_q,
  output logic [IDX_W-1:0]  casc_idx_q
);

  logic [N_IRQ-1:0] irr_d, isr_d;
  logic [IDX_W-1:0] top_d, casc_idx_d;
  logic [VEC_W-1:0] vec_d;
  logic             vec_valid_d, casc_valid_d;
  logic             rotate_en;

  always_comb begin
    irr_d = irq_in;
    if (ack_fire) irr_d[sel_idx] = 1'b0;

    isr_d = isr_q;
    if (eoi_valid) isr_d[eoi_tgt] = 1'b0;
    if (ack_fire)  isr_d[sel_idx] = 1'b1;
  end

  assign rotate_en = eoi_valid && rot && isr_q[eoi_tgt];

  always_comb begin
    top_d = top_q;
    if (rotate_en) begin
      top_d = (eoi_tgt == IDX_W'(N_IRQ - 1)) ? '0 : eoi_tgt + 1'b1;
    end
  end

  always_comb begin
    vec_valid_d  = ack_fire && !slave[sel_idx];
    casc_valid_d = ack_fire &&  slave[sel_idx];
    vec_d        = (ack_fire && !slave[sel_idx]) ? {base, sel_idx} : vec_q;
    casc_idx_d   = (ack_fire &&  slave[sel_idx]) ? sel_idx : casc_idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q        <= '0;
      isr_q        <= '0;
      top_q        <= '0;
      vec_q        <= '0;
      vec_valid_q  <= 1'b0;
      casc_valid_q <= 1'b0;
      casc_idx_q   <= '0;
    end else begin
      irr_q        <= irr_d;
      isr_q        <= isr_d;
      top_q        <= top_d;
      vec_q        <= vec_d;
      vec_valid_q  <= vec_valid_d;
      casc_valid_q <= casc_valid_d;
      casc_idx_q   <= casc_idx_d;
    end
  end

endmodule

// File: rtl/vic_rotor.sv
module vic_rotor #(
  parameter int N_IRQ  = 8,
  parameter int DATA_W = 8,
  parameter int VEC_W  = 8,
  parameter int IDX_W  = $clog2(N_IRQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              int_req,
  input  logic              int_ack,
  output logic [VEC_W-1:0]  vec_out,
  output logic              vec_valid,
  output logic              casc_valid,
  output logic [IDX_W-1:0]  casc_idx
);

  localparam int BASE_W = VEC_W - IDX_W;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [N_IRQ-1:0]  mask_q, slave_q, irr_q, isr_q;
  logic              rot_q;
  logic [BASE_W-1:0] base_q;
  logic              eoi_fire, eoi_nonspec, eoi_valid;
  logic [IDX_W-1:0]  eoi_idx, eoi_tgt;
  logic [IDX_W-1:0]  top_q, top_eff;
  logic              isr_any, req_any, ack_fire;
  logic [IDX_W-1:0]  isr_idx, req_idx;
  logic [N_IRQ-1:0]  allowed, eff_mask, cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  vic_regs #(
    .N_IRQ(N_IRQ), .IDX_W(IDX_W), .DATA_W(DATA_W), .BASE_W(BASE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .mask_q(mask_q), .slave_q(slave_q), .rot_q(rot_q),
    .base_q(base_q), .eoi_fire(eoi_fire), .eoi_nonspec(eoi_nonspec),
    .eoi_idx(eoi_idx)
  );

  assign top_eff = rot_q ? top_q : '0;

  vic_prio_pick #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_isr_pick (
    .cand(isr_q), .start(top_eff), .found(isr_any), .idx(isr_idx)
  );

  vic_rank_gate #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_gate (
    .top_ptr(top_eff), .isr_any(isr_any), .isr_idx(isr_idx),
    .slave(slave_q), .allowed(allowed)
  );

  assign eff_mask = mask_q & ~(slave_q & isr_q);
  assign cand     = irr_q & ~eff_mask & allowed;

  vic_prio_pick #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_req_pick (
    .cand(cand), .start(top_eff), .found(req_any), .idx(req_idx)
  );

  assign int_req   = req_any;
  assign ack_fire  = int_ack && req_any;
  assign eoi_tgt   = eoi_nonspec ? isr_idx : eoi_idx;
  assign eoi_valid = eoi_fire && (!eoi_nonspec || isr_any);

  vic_service #(
    .N_IRQ(N_IRQ), .IDX_W(IDX_W), .BASE_W(BASE_W), .VEC_W(VEC_W)
  ) u_svc (
    .clk(clk), .rst_n(rst_sync_n), .irq_in(irq_in), .ack_fire(ack_fire),
    .sel_idx(req_idx), .eoi_valid(eoi_valid), .eoi_tgt(eoi_tgt),
    .rot(rot_q), .base(base_q), .slave(slave_q), .irr_q(irr_q),
    .isr_q(isr_q), .top_q(top_q), .vec_q(vec_out),
    .vec_valid_q(vec_valid), .casc_valid_q(casc_valid),
    .casc_idx_q(casc_idx)
  );

endmodule

// File: rtl/vic_rotor_checker.sv
module vic_rotor_checker #(
  parameter int N_IRQ  = 8,
  parameter int DATA_W = 8,
  parameter int VEC_W  = 8,
  parameter int IDX_W  = $clog2(N_IRQ)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_IRQ-1:0]  irq_in,
  input logic              int_req,
  input logic              int_ack,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [VEC_W-1:0]  vec_out,
  input logic              vec_valid,
  input logic              casc_valid,
  input logic [N_IRQ-1:0]  mask_q,
  input logic [N_IRQ-1:0]  isr_q
);

  assert_req_from_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> $past(|irq_in));

  assert_masked_never_vectored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !$past(mask_q[vec_out[IDX_W-1:0]]));

  assert_ack_one_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_req) |=> (vec_valid ^ casc_valid));

  assert_isr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(isr_q) <= $past($countones(isr_q)) + 1));

  assert_eoi_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd3 && !reg_wdata[7] && !int_ack)
      |=> !isr_q[$past(reg_wdata[IDX_W-1:0])]);

  assert_stray_ack_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_ack && int_req) |=> (!vec_valid && !casc_valid));

endmodule

bind vic_rotor vic_rotor_checker #(
  .N_IRQ(N_IRQ), .DATA_W(DATA_W), .VEC_W(VEC_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .irq_in(irq_in), .int_req(int_req),
  .int_ack(int_ack), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .vec_out(vec_out), .vec_valid(vec_valid),
  .casc_valid(casc_valid), .mask_q(mask_q), .isr_q(isr_q)
);

// File: tb/sim_vic_rotor.sv
module sim_vic_rotor;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       int_ack = 1'b0;
  logic       int_req, vec_valid, casc_valid;
  logic [7:0] vec_out;
  logic [2:0] casc_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [8:0] exp_q[$];

  always #5 clk = ~clk;

  vic_rotor u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .int_req(int_req),
    .int_ack(int_ack), .vec_out(vec_out), .vec_valid(vec_valid),
    .casc_valid(casc_valid), .casc_idx(casc_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  // Driver: pushes the expected result, then acknowledges.
  task automatic ack_expect(input logic slave, input logic [7:0] val);
    exp_q.push_back({slave, val});
    @(negedge clk);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  task automatic stray_ack();
    @(negedge clk);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  // Monitor: pops and compares whenever the design produces a result.
  always @(negedge clk) begin
    if (rst_n && (vec_valid || casc_valid)) begin
      if (exp_q.size() == 0) begin
        chk("R12 output without expected ack", {vec_valid, casc_valid}, 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if (e[8]) begin
          chk("R10 cascade strobe", {vec_valid, casc_valid}, 2'b01);
          chk("R10 cascade index", {5'b0, casc_idx}, e[7:0]);
        end else begin
          chk("R5 vector strobe", {vec_valid, casc_valid}, 2'b10);
          chk("R5 vector value", vec_out, e[7:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    irq_in = 8'h08;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: everything masked after reset
    chk("R1 int_req after reset", int_req, 0);
    chk("R1 vec_valid after reset", vec_valid, 0);
    chk("R1 casc_valid after reset", casc_valid, 0);

    // base 0x15, fixed mode; only line 5 masked
    reg_write(2'd1, 8'hA8);
    reg_write(2'd0, 8'h20);
    set_irq(8'h20);
    repeat (3) @(negedge clk);
    chk("R3 masked line no request", int_req, 0);

    set_irq(8'h60);
    chk("R2 no request before sampling edge", int_req, 0);
    @(negedge clk);
    chk("R2 request after one edge", int_req, 1);

    set_irq(8'h68);
    @(negedge clk);
    chk("R4 request with lines 3,5,6", int_req, 1);
    ack_expect(1'b0, 8'hAB);                    // R4: line 3 wins
    chk("R6 lower line 6 blocked by 3", int_req, 0);
    @(negedge clk);
    chk("R5 vec_valid one cycle only", vec_valid, 0);
    chk("R6 still blocked", int_req, 0);

    set_irq(8'h6A);
    @(negedge clk);
    chk("R6 higher line 1 nests", int_req, 1);
    ack_expect(1'b0, 8'hA9);
    chk("R6 all blocked with 1,3 in service", int_req, 0);

    stray_ack();
    chk("R12 stray ack no vector", vec_valid, 0);
    chk("R12 stray ack no cascade", casc_valid, 0);
    chk("R12 stray ack no request change", int_req, 0);

    reg_write(2'd3, 8'h80);                     // non-specific: frees line 1
    chk("R8 line 1 freed by non-specific end", int_req, 1);
    set_irq(8'h68);
    @(negedge clk);
    chk("R8 line 3 still in service", int_req, 0);

    reg_write(2'd3, 8'h03);
    chk("R7 line 3 freed by specific end", int_req, 1);
    ack_expect(1'b0, 8'hAB);
    reg_write(2'd3, 8'h03);
    set_irq(8'h60);
    @(negedge clk);
    ack_expect(1'b0, 8'hAE);                    // R3: line 5 skipped
    reg_write(2'd3, 8'h06);
    set_irq(8'h00);

    // R9: rotating mode
    reg_write(2'd1, 8'hA9);
    reg_write(2'd0, 8'h00);
    set_irq(8'h11);
    @(negedge clk);
    ack_expect(1'b0, 8'hA8);                    // R9 pointer at 0: line 0
    reg_write(2'd3, 8'h00);
    ack_expect(1'b0, 8'hAC);                    // R9 line 0 now weakest: line 4
    reg_write(2'd3, 8'h04);
    ack_expect(1'b0, 8'hA8);                    // R9 pointer at 5: line 0
    reg_write(2'd3, 8'h00);
    set_irq(8'h80);
    @(negedge clk);
    ack_expect(1'b0, 8'hAF);
    reg_write(2'd3, 8'h07);                     // R9 wrap: pointer to 0
    set_irq(8'h81);
    @(negedge clk);
    chk("R9 request after wrap", int_req, 1);
    ack_expect(1'b0, 8'hA8);                    // R9 line 0 beats line 7
    reg_write(2'd3, 8'h00);
    set_irq(8'h00);
    @(negedge clk);

    // R10 / R11: cascade line 2, fixed mode
    reg_write(2'd1, 8'hA8);
    reg_write(2'd2, 8'h04);
    set_irq(8'h04);
    @(negedge clk);
    ack_expect(1'b1, 8'h02);
    reg_write(2'd0, 8'h04);
    @(negedge clk);
    chk("R11 cascade line forwarded despite mask", int_req, 1);
    ack_expect(1'b1, 8'h02);
    reg_write(2'd3, 8'h02);
    @(negedge clk);
    chk("R11 mask applies after service ends", int_req, 0);
    set_irq(8'h00);
    repeat (3) @(negedge clk);

    chk("R5 all expected results seen", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule